// File: doc/BRIEF.md
# Proximity Tag Frame Sequencer

This block turns a stored 40-bit identification value into the fixed 64-bit frame that a passive proximity tag repeats over and over while it is energised. The frame opens with a run of nine ones. The ID follows as ten rows of four bits, and each row carries an even parity bit. A row of four column parity bits comes next, and a single zero stop bit closes the frame. The parity layout means that nine consecutive ones can never appear inside the payload, so a reader can lock onto the header without ambiguity.

The block runs from the field clock. Each bit slot lasts either 64 or 32 field-clock periods, chosen by one input. The block drives the current frame bit on a serial output and pulses a strobe at the start of every slot. It raises a frame-start flag together with the first header bit. When the last bit has gone out, the frame restarts at once. The ID is captured only at the edge that begins a frame, so an update to the ID never splits a frame. Line coding of the serial bit belongs to a later stage.

Top module: `tag_frame_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to bit 0 of slot 0. In the first cycle after release, `bit_strobe` and `frame_start` are both 1 and `serial_out` is 1.
- R2: Frame positions 0 to 8 (the header) are always 1.
- R3: For row r (0..9) and column c (0..3), frame position 9+5r+c carries `id_in` bit 39-4r-c, so the top 8 ID bits (the customer field) fill rows 0 and 1.
- R4: Frame position 13+5r carries the even parity of row r's four data bits (their XOR).
- R5: Frame position 59+c (c = 0..3) carries the XOR of column c over all ten rows.
- R6: Frame position 63 (the stop bit) is always 0.
- R7: One slot lasts 64 field-clock cycles when `rate_short` is 0 and 32 when it is 1. `bit_strobe` is high only in the first cycle of each slot.
- R8: After position 63 the frame restarts at position 0 with no gap. `frame_start` is high exactly in the first cycle of each frame.
- R9: The ID used for a frame is the value of `id_in` at the clock edge that begins that frame (the last reset edge, for the first frame). Changes to `id_in` at any other time have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_short | input | 1 | Slot length select: 0 = 64 cycles, 1 = 32 cycles |
| id_in | input | 40 | Stored identification value |
| serial_out | output | 1 | Current frame bit |
| bit_strobe | output | 1 | High in the first cycle of each bit slot |
| frame_start | output | 1 | High in the first cycle of each frame |

## Verification
All three outputs decode directly from registered state, so each changes in the cycle right after the edge that updates the slot counter, the bit index or the captured frame. Frame position p is therefore due in cycles p·N through p·N+N−1 after release, where N is the slot length. The bench counts cycles from the reset release and samples on the falling edge, where the state is already settled. For every cycle it predicts the strobe, the frame-start flag and the bit. For the ID it uses the value it held on `id_in` just before the edge that began the current frame. That is how it checks that an ID change in mid-frame shows up only one frame later.

// File: rtl/tag_frame_pkg.sv
package tag_frame_pkg;
  localparam int HDR_LEN   = 9;
  localparam int ROWS      = 10;
  localparam int COLS      = 4;
  localparam int ID_W      = ROWS * COLS;
  localparam int ROW_SPAN  = COLS + 1;
  localparam int COLP_BASE = HDR_LEN + ROWS * ROW_SPAN;
  localparam int FRAME_LEN = COLP_BASE + COLS + 1;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef logic [ID_W-1:0]      tag_id_t;
  typedef logic [FRAME_LEN-1:0] frame_t;
  typedef logic [IDX_W-1:0]     bit_idx_t;

  // ID cell of row r, column c; row 0 column 0 is the ID's top bit
  function automatic logic id_cell(tag_id_t id, int r, int c);
    return id[ID_W-1-(r*COLS+c)];
  endfunction

  function automatic logic row_parity(tag_id_t id, int r);
    logic p;
    p = 1'b0;
    for (int c = 0; c < COLS; c++) p ^= id_cell(id, r, c);
    return p;
  endfunction

  function automatic logic col_parity(tag_id_t id, int c);
    logic p;
    p = 1'b0;
    for (int r = 0; r < ROWS; r++) p ^= id_cell(id, r, c);
    return p;
  endfunction

  // frame bit k is the k-th bit transmitted
  function automatic frame_t build_frame(tag_id_t id);
    frame_t f;
    f = '0;
    for (int h = 0; h < HDR_LEN; h++) f[h] = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) f[HDR_LEN + r*ROW_SPAN + c] = id_cell(id, r, c);
      f[HDR_LEN + r*ROW_SPAN + COLS] = row_parity(id, r);
    end
    for (int c = 0; c < COLS; c++) f[COLP_BASE + c] = col_parity(id, c);
    f[FRAME_LEN-1] = 1'b0;
    return f;
  endfunction
endpackage

// File: rtl/tag_slot_timer.sv
module tag_slot_timer #(
  parameter int SLOT_LONG  = 64,
  parameter int SLOT_SHORT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_short,
  output logic slot_start,
  output logic slot_end
);
  localparam int CNT_W = $clog2(SLOT_LONG);
  localparam int LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [LIM_W-1:0] limit;

  assign limit      = rate_short ? LIM_W'(SLOT_SHORT) : LIM_W'(SLOT_LONG);
  assign slot_start = (cnt == '0);
  assign slot_end   = ({1'b0, cnt} >= (limit - LIM_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (slot_end) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R7: the strobe lasts a single cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start);
  // R7: a slot end is followed by a slot start
  a_r7_end_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> slot_start);
endmodule

// File: rtl/tag_bit_counter.sv
module tag_bit_counter
  import tag_frame_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     advance,
  output bit_idx_t idx,
  output logic     frame_wrap
);
  localparam bit_idx_t LAST = bit_idx_t'(FRAME_LEN - 1);

  assign frame_wrap = advance && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          idx <= '0;
    else if (frame_wrap) idx <= '0;
    else if (advance)    idx <= idx + 1'b1;
  end

  // R8: the index moves only at a slot boundary
  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(idx));
  // R8: wrap returns straight to position 0
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (idx == '0));
endmodule

// File: rtl/tag_frame_store.sv
module tag_frame_store
  import tag_frame_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  tag_id_t  id_in,
  input  bit_idx_t idx,
  output logic     bit_out
);
  frame_t frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n || load) frame_q <= build_frame(id_in);
  end

  assign bit_out = frame_q[idx];

  // R9: the captured frame changes only at a frame boundary
  a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(frame_q));
endmodule

// File: rtl/tag_frame_seq.sv
module tag_frame_seq
  import tag_frame_pkg::*;
#(
  parameter int SLOT_LONG  = 64,
  parameter int SLOT_SHORT = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rate_short,
  input  logic [ID_W-1:0] id_in,
  output logic            serial_out,
  output logic            bit_strobe,
  output logic            frame_start
);
  logic     slot_start;
  logic     slot_end;
  logic     frame_wrap;
  bit_idx_t idx;

  tag_slot_timer #(
    .SLOT_LONG (SLOT_LONG),
    .SLOT_SHORT(SLOT_SHORT)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_short(rate_short),
    .slot_start(slot_start),
    .slot_end  (slot_end)
  );

  tag_bit_counter i_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (slot_end),
    .idx       (idx),
    .frame_wrap(frame_wrap)
  );

  tag_frame_store i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (frame_wrap),
    .id_in  (id_in),
    .idx    (idx),
    .bit_out(serial_out)
  );

  assign bit_strobe  = slot_start;
  assign frame_start = slot_start && (idx == '0);

  // R2: header positions drive ones
  a_r2_header_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (idx < bit_idx_t'(HDR_LEN)) |-> serial_out);
  // R6: stop position drives zero
  a_r6_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == bit_idx_t'(FRAME_LEN - 1)) |-> !serial_out);
  // R8: frame start coincides with a strobe and a header one
  a_r8_start_header: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_strobe && serial_out));
endmodule

// File: tb/test_tag_frame_seq.sv
module test_tag_frame_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_short = 1'b1;
  logic [39:0] id_in = '0;
  logic        serial_out, bit_strobe, frame_start;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_frame_seq i_tag_frame_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_short (rate_short),
    .id_in      (id_in),
    .serial_out (serial_out),
    .bit_strobe (bit_strobe),
    .frame_start(frame_start)
  );

  // expected bit at a frame position, decoded from the position
  function automatic logic exp_bit(logic [39:0] id, int pos);
    int r, c;
    logic p;
    p = 1'b0;
    if (pos < 9) return 1'b1;
    if (pos == 63) return 1'b0;
    if (pos >= 59) begin
      for (int k = 0; k < 10; k++) p ^= id[39 - 4*k - (pos - 59)];
      return p;
    end
    r = (pos - 9) / 5;
    c = (pos - 9) % 5;
    if (c < 4) return id[39 - 4*r - c];
    return ^id[39 - 4*r -: 4];
  endfunction

  function automatic string pos_req(int pos);
    if (pos < 9) return "R2";
    if (pos == 63) return "R6";
    if (pos >= 59) return "R5";
    if ((pos - 9) % 5 == 4) return "R4";
    return "R3";
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what, input int cyc);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  task automatic run_phase(input logic rs, input logic [39:0] id0, input int nframes, input bit change);
    int n = rs ? 32 : 64;
    int len = n * 64;
    logic [39:0] frm_id;
    rate_short = rs;
    id_in = id0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    frm_id = id0;
    for (int k = 0; k < nframes * len; k++) begin
      int pos;
      string tag;
      if (k > 0) @(negedge clk);
      if (k % len == 0) frm_id = id_in;   // value at the edge starting this frame (R9)
      pos = (k / n) % 64;
      tag = (k == 0) ? "R1" : ((change && k >= len) ? "R9" : pos_req(pos));
      check(bit_strobe, (k % n == 0), (k == 0) ? "R1" : "R7", "bit_strobe", k);
      check(frame_start, (k % len == 0), (k == 0) ? "R1" : "R8", "frame_start", k);
      check(serial_out, exp_bit(frm_id, pos), tag, "serial_out", k);
      if (change && (k % len == len / 2)) id_in = {8'($urandom), $urandom};
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    run_phase(1'b1, 40'h00_0000_0000, 1, 1'b0);
    run_phase(1'b1, 40'hFF_FFFF_FFFF, 1, 1'b0);
    run_phase(1'b1, 40'h80_0000_0001, 1, 1'b0);
    for (int i = 0; i < 4; i++) run_phase(1'b1, {8'($urandom), $urandom}, 2, 1'b1);
    run_phase(1'b0, {8'($urandom), $urandom}, 2, 1'b0);
    run_phase(1'b0, {8'($urandom), $urandom}, 2, 1'b1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule